// File: doc/BRIEF.md
# Thermal threshold interrupt monitor

This block watches a stream of filtered 12-bit temperature codes and compares each one against five programmable limits. It raises sticky status flags when a code climbs over the hot limit, drops under the cold limit, or leaves a window set by an upper and a lower offset limit. Each flag has an enable bit. The single level-high interrupt line is active while any enabled flag is set.

Software programs the limits and the enable mask through a simple write port. It reads any register back through a combinational read port. When the interrupt arrives, software reads the status word and writes ones back to clear the flags it has handled. The hot comparison uses the larger of two hot limit registers. Crossing it raises two flags at once, so that two consumers of the hot event can each clear their own copy.

Register map (word addresses on the 3-bit address buses):

| Address | Contents |
|---|---|
| 0 | status, write-one-to-clear |
| 1 | enable mask |
| 2 | hot limit A |
| 3 | hot limit B |
| 4 | cold limit |
| 5 | upper offset limit |
| 6 | lower offset limit |
| 7 | unused |

Top module: `thermtrip_monitor`

## Requirements
- R1: After reset, the status word, the enable mask and the interrupt are 0. Both hot limits and the upper offset limit read 0xFFF. The cold limit and the lower offset limit read 0.
- R2: A write to address 2, 3, 4, 5 or 6 stores wr_data[11:0]. Reads of these addresses return that value in bits 11:0 and zeros above. A write to address 1 stores wr_data[5:0] as the enable mask, which reads back in bits 5:0.
- R3: A valid code strictly greater than the larger of the two hot limits sets status bit 0 and status bit 5 together, visible on the clock edge that samples it. A code equal to that larger limit sets neither.
- R4: A valid code strictly below the cold limit sets status bit 1.
- R5: A valid code strictly above the upper offset limit sets status bit 2.
- R6: A valid code strictly below the lower offset limit sets status bit 3.
- R7: Status bits stay set until cleared. A write to address 0 clears exactly the bits written as 1 and leaves the others. Status bit 4 always reads 0. Reads of address 0 return the status word in bits 5:0.
- R8: If a comparison sets a status bit in the same cycle that a write clears it, the bit stays set.
- R9: When samp_vld is low, samp_code has no effect on the status word.
- R10: irq is high exactly when some status bit and the enable bit at the same position are both 1. It follows the status word and the enable mask in the same cycle.
- R11: A write to address 7 changes no register, and reads of address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | Sample strobe; the comparisons run only when it is high |
| samp_code | input | 12 | Filtered temperature code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational readback of the addressed register |
| status | output | 6 | Sticky status word |
| irq | output | 1 | Level-high interrupt |

## Verification
The assertions assume a stable configuration around the sampled edge. They also assume that the clear mask carried by a status write refers only to the flags present before that edge. The stimulus therefore changes every input only on the falling clock edge. It issues one write per cycle and never a read and a write that depend on each other within one cycle. Equal-to-limit codes, a swapped ordering of the two hot limits, and a clear that collides with a new trip are each driven on purpose. Idle cycles with extreme codes and the strobe low show that unsampled codes leave the status unchanged.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    localparam int STAT_W = 6;

    localparam int ST_HOT   = 0;
    localparam int ST_COLD  = 1;
    localparam int ST_UPPER = 2;
    localparam int ST_LOWER = 3;
    localparam int ST_RSVD  = 4;
    localparam int ST_HOT_B = 5;

    localparam logic [2:0] ADR_STAT  = 3'd0;
    localparam logic [2:0] ADR_EN    = 3'd1;
    localparam logic [2:0] ADR_HOTA  = 3'd2;
    localparam logic [2:0] ADR_HOTB  = 3'd3;
    localparam logic [2:0] ADR_COLD  = 3'd4;
    localparam logic [2:0] ADR_UPPER = 3'd5;
    localparam logic [2:0] ADR_LOWER = 3'd6;

    localparam int NUM_LANES = 4;

endpackage

// File: rtl/thermtrip_cfg.sv
module thermtrip_cfg
    import thermtrip_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STAT_W-1:0] en_o,
    output logic [CODE_W-1:0] hota_o,
    output logic [CODE_W-1:0] hotb_o,
    output logic [CODE_W-1:0] cold_o,
    output logic [CODE_W-1:0] upper_o,
    output logic [CODE_W-1:0] lower_o
);

    typedef struct packed {
        logic [STAT_W-1:0] en;
        logic [CODE_W-1:0] hota;
        logic [CODE_W-1:0] hotb;
        logic [CODE_W-1:0] cold;
        logic [CODE_W-1:0] upper;
        logic [CODE_W-1:0] lower;
    } cfg_t;

    localparam logic [CODE_W-1:0] LIM_TOP = '1;
    localparam logic [CODE_W-1:0] LIM_BOT = '0;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(ADR_EN):    cfg_d.en    = wr_data[STAT_W-1:0];
                ADDR_W'(ADR_HOTA):  cfg_d.hota  = wr_data[CODE_W-1:0];
                ADDR_W'(ADR_HOTB):  cfg_d.hotb  = wr_data[CODE_W-1:0];
                ADDR_W'(ADR_COLD):  cfg_d.cold  = wr_data[CODE_W-1:0];
                ADDR_W'(ADR_UPPER): cfg_d.upper = wr_data[CODE_W-1:0];
                ADDR_W'(ADR_LOWER): cfg_d.lower = wr_data[CODE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en    <= '0;
            cfg_q.hota  <= LIM_TOP;
            cfg_q.hotb  <= LIM_TOP;
            cfg_q.cold  <= LIM_BOT;
            cfg_q.upper <= LIM_TOP;
            cfg_q.lower <= LIM_BOT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o    = cfg_q.en;
    assign hota_o  = cfg_q.hota;
    assign hotb_o  = cfg_q.hotb;
    assign cold_o  = cfg_q.cold;
    assign upper_o = cfg_q.upper;
    assign lower_o = cfg_q.lower;

    // R2
    cold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADR_COLD)) |=> (cold_o == $past(wr_data[CODE_W-1:0])));

    // R11
    spare_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(7)) |=> $stable(cfg_q));

endmodule

// File: rtl/thermtrip_cmp.sv
module thermtrip_cmp
    import thermtrip_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              vld_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CODE_W-1:0] hota_i,
    input  logic [CODE_W-1:0] hotb_i,
    input  logic [CODE_W-1:0] cold_i,
    input  logic [CODE_W-1:0] upper_i,
    input  logic [CODE_W-1:0] lower_i,
    output logic [STAT_W-1:0] hit_o
);

    // lane order matches status bits 0..3; a 1 selects an above-limit test
    localparam logic [NUM_LANES-1:0] ABOVE = 4'b0101;

    logic [CODE_W-1:0]    hot_eff;
    logic [CODE_W-1:0]    lim [NUM_LANES];
    logic [NUM_LANES-1:0] trip;

    assign hot_eff = (hota_i > hotb_i) ? hota_i : hotb_i;

    assign lim[ST_HOT]   = hot_eff;
    assign lim[ST_COLD]  = cold_i;
    assign lim[ST_UPPER] = upper_i;
    assign lim[ST_LOWER] = lower_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        if (ABOVE[g]) begin : g_above
            assign trip[g] = vld_i && (code_i > lim[g]);
        end else begin : g_below
            assign trip[g] = vld_i && (code_i < lim[g]);
        end
    end

    always_comb begin
        hit_o           = '0;
        hit_o[ST_HOT]   = trip[ST_HOT];
        hit_o[ST_COLD]  = trip[ST_COLD];
        hit_o[ST_UPPER] = trip[ST_UPPER];
        hit_o[ST_LOWER] = trip[ST_LOWER];
        hit_o[ST_HOT_B] = trip[ST_HOT];
    end

endmodule

// File: rtl/thermtrip_status.sv
module thermtrip_status
    import thermtrip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    input  logic [STAT_W-1:0] en_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d               = st_q;
        st_d.stat          = (st_q.stat & ~clr_i) | set_i;
        st_d.stat[ST_RSVD] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.stat;
    assign irq_o    = |(st_q.stat & en_i);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ($past(set_i) & ~(STAT_W'(1) << ST_RSVD))) ==
                  ($past(set_i) & ~(STAT_W'(1) << ST_RSVD))));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ($past(status_o) & ~$past(clr_i))) ==
                  ($past(status_o) & ~$past(clr_i))));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o != '0));

endmodule

// File: rtl/thermtrip_monitor.sv
module thermtrip_monitor
    import thermtrip_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_vld,
    input  logic [CODE_W-1:0] samp_code,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic [STAT_W-1:0] en;
    logic [CODE_W-1:0] hota, hotb, cold, upper, lower;
    logic [STAT_W-1:0] hit;
    logic [STAT_W-1:0] clr;

    thermtrip_cfg #(
        .CODE_W (CODE_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_o    (en),
        .hota_o  (hota),
        .hotb_o  (hotb),
        .cold_o  (cold),
        .upper_o (upper),
        .lower_o (lower)
    );

    thermtrip_cmp #(
        .CODE_W (CODE_W)
    ) i_cmp (
        .vld_i   (samp_vld),
        .code_i  (samp_code),
        .hota_i  (hota),
        .hotb_i  (hotb),
        .cold_i  (cold),
        .upper_i (upper),
        .lower_i (lower),
        .hit_o   (hit)
    );

    assign clr = (wr_en && wr_addr == ADDR_W'(ADR_STAT)) ? wr_data[STAT_W-1:0] : '0;

    thermtrip_status i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (hit),
        .clr_i    (clr),
        .en_i     (en),
        .status_o (status),
        .irq_o    (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(ADR_STAT):  rd_data = DATA_W'(status);
            ADDR_W'(ADR_EN):    rd_data = DATA_W'(en);
            ADDR_W'(ADR_HOTA):  rd_data = DATA_W'(hota);
            ADDR_W'(ADR_HOTB):  rd_data = DATA_W'(hotb);
            ADDR_W'(ADR_COLD):  rd_data = DATA_W'(cold);
            ADDR_W'(ADR_UPPER): rd_data = DATA_W'(upper);
            ADDR_W'(ADR_LOWER): rd_data = DATA_W'(lower);
            default:            rd_data = '0;
        endcase
    end

    // R3
    hot_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && samp_code > hota && samp_code > hotb) |=> (status[ST_HOT] && status[ST_HOT_B]));

    // R4
    cold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && samp_code < cold) |=> status[ST_COLD]);

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |=> ((status & ~$past(status)) == '0));

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !status[ST_RSVD]);

endmodule

// File: tb/test_thermtrip_monitor.sv
module test_thermtrip_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_vld = 1'b0;
    logic [11:0] samp_code = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [5:0]  status;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_en, m_hota, m_hotb, m_cold, m_upper, m_lower, m_st;

    always #10 clk = ~clk;

    thermtrip_monitor i_thermtrip_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_vld  (samp_vld),
        .samp_code (samp_code),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .status    (status),
        .irq       (irq)
    );

    function automatic int model_read(int a);
        case (a)
            0: return m_st;
            1: return m_en;
            2: return m_hota;
            3: return m_hotb;
            4: return m_cold;
            5: return m_upper;
            6: return m_lower;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_en = 0; m_st = 0;
        m_hota = 'hFFF; m_hotb = 'hFFF; m_upper = 'hFFF;
        m_cold = 0; m_lower = 0;
    endtask

    task automatic model_edge();
        int hits = 0;
        int clr = 0;
        int code = int'(samp_code);
        int hot = (m_hota > m_hotb) ? m_hota : m_hotb;
        if (samp_vld) begin
            if (code > hot)     hits |= 'h21;
            if (code < m_cold)  hits |= 'h02;
            if (code > m_upper) hits |= 'h04;
            if (code < m_lower) hits |= 'h08;
        end
        if (wr_en && wr_addr == 3'd0) clr = int'(wr_data[5:0]);
        m_st = ((m_st & ~clr) | hits) & 'h2F;
        if (wr_en) begin
            case (wr_addr)
                3'd1: m_en    = int'(wr_data[5:0]);
                3'd2: m_hota  = int'(wr_data[11:0]);
                3'd3: m_hotb  = int'(wr_data[11:0]);
                3'd4: m_cold  = int'(wr_data[11:0]);
                3'd5: m_upper = int'(wr_data[11:0]);
                3'd6: m_lower = int'(wr_data[11:0]);
                default: ;
            endcase
        end
    endtask

    task automatic compare(string tag);
        int  e_rd = model_read(int'(rd_addr));
        bit  e_irq = (m_st & m_en) != 0;
        n_chk++;
        if (status !== 6'(m_st) || irq !== e_irq || rd_data !== 32'(e_rd)) begin
            n_bad++;
            $display("FAIL %s: status=%h irq=%b rd[%0d]=%h expected status=%h irq=%b rd=%h",
                     tag, status, irq, rd_addr, rd_data, 6'(m_st), e_irq, 32'(e_rd));
        end
    endtask

    // one clock: inputs were set at the falling edge, model follows the rising edge
    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
        @(negedge clk);
        samp_vld = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic wr(int a, int d, string tag);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
        cyc(tag);
    endtask

    task automatic smp(int c, string tag);
        samp_vld = 1'b1; samp_code = 12'(c);
        cyc(tag);
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            cyc(tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        n_chk++;
        if (status !== 6'd0 || irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: status=%h irq=%b expected 00 0", status, irq);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values through readback
        sweep("R1");

        // R2 field widths and readback, R11 spare address
        wr(2, 'hABCDE123, "R2");
        wr(3, 'h7654_3456, "R2");
        wr(4, 'hFFFF_F010, "R2");
        wr(5, 'h1234_5EEE, "R2");
        wr(6, 'h0000_0002, "R2");
        wr(1, 'hFFFF_FFFF, "R2");
        sweep("R2");
        wr(7, 'hFFFF_FFFF, "R11");
        sweep("R11");

        // quiet configuration
        wr(1, 0, "R2");
        wr(2, 'hFFF, "R2"); wr(3, 'hFFF, "R2");
        wr(4, 0, "R2"); wr(5, 'hFFF, "R2"); wr(6, 0, "R2");
        rd_addr = 3'd0;

        // R3 hot limit B larger
        wr(2, 'h800, "R3"); wr(3, 'h900, "R3");
        smp('h900, "R3");
        smp('h8FF, "R3");
        smp('h901, "R3");
        wr(1, 'h01, "R10");
        cyc("R10");
        wr(0, 'h01, "R7");
        wr(1, 'h20, "R10");
        wr(0, 'h20, "R7");
        // R3 hot limit A larger
        wr(2, 'hA00, "R3");
        smp('h9FF, "R3");
        smp('hA00, "R3");
        smp('hA01, "R3");
        wr(0, 'h3F, "R7");
        wr(2, 'hFFF, "R3"); wr(3, 'hFFF, "R3");

        // R4 cold
        wr(4, 'h100, "R4");
        smp('h100, "R4");
        smp('h0FF, "R4");
        wr(1, 'h02, "R10");
        wr(0, 'h02, "R4");
        wr(4, 0, "R4");

        // R5 upper offset
        wr(5, 'h600, "R5");
        smp('h600, "R5");
        smp('h601, "R5");
        wr(1, 'h04, "R10");
        // R6 lower offset
        wr(6, 'h200, "R6");
        smp('h200, "R6");
        smp('h1FF, "R6");
        wr(1, 'h08, "R10");
        // R7 writing zeros clears nothing, single bit clear keeps the other
        wr(0, 'h00, "R7");
        wr(0, 'h04, "R7");
        wr(0, 'h10, "R7");
        wr(0, 'h08, "R7");

        // R8 trip and clear in the same cycle
        samp_vld = 1'b1; samp_code = 12'h700;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h3F;
        cyc("R8");
        samp_vld = 1'b1; samp_code = 12'h100;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0C;
        cyc("R8");
        wr(0, 'h3F, "R7");

        // R9 strobe low with extreme codes
        wr(1, 'h3F, "R9");
        wr(4, 'h800, "R9");
        samp_vld = 1'b0; samp_code = 12'hFFF; cyc("R9");
        samp_vld = 1'b0; samp_code = 12'h000; cyc("R9");
        samp_vld = 1'b0; samp_code = 12'h7FF; cyc("R9");
        smp('h000, "R10");
        wr(1, 'h00, "R10");
        wr(1, 'h0A, "R10");
        wr(0, 'h3F, "R7");
        sweep("R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule